// File: doc/BRIEF.md
# Fixed-Page Stack Pointer Sequencer

This block owns the hardware stack of a small 8-bit processor with a 13-bit address space. It keeps a 6-bit pointer whose upper address bits are wired to a constant, so the stack always lies in the 64-byte window 0x0040 to 0x007F. When the pointer runs past either end of that window it wraps to the other end, and the older data there is overwritten.

On a command the block carries out one of four stack transfers: it saves a subroutine return address (two bytes), restores one, saves a full interrupt frame (five bytes: the program counter, the index register, the accumulator and the condition codes), or restores one. Each transfer makes one memory access per cycle. The block drives the address, the write data and the write or read strobe, and loads the restored register values from the read data. The processor core issues the commands and takes the restored values. The memory and the instruction decode sit outside the block.

Top module: `stkseq_top`

## Requirements
- R1: During and after reset the stack pointer output `sp_out` reads 0x007F, `busy`, `done`, `mem_we` and `mem_re` are 0, and `pc_out`, `x_out`, `a_out` and `cc_out` are 0.
- R2: When `rsp_req` is high in an idle cycle, `sp_out` reads 0x007F from the next cycle on.
- R3: `sp_out` and every `mem_addr` driven during an access have bits 12:6 equal to 0000001, so they lie in 0x0040..0x007F.
- R4: A save access writes at the current pointer, and the pointer is one lower in the next cycle.
- R5: A restore access first steps the pointer up by one and reads at the new pointer value: `mem_addr` is `sp_out`+1 within the page, and `sp_out` equals that address in the next cycle.
- R6: The pointer wraps modulo 64 inside the page: a save at 0x0040 leaves it at 0x007F, and a restore with the pointer at 0x007F reads 0x0040.
- R7: `cmd_op`=2 saves an interrupt frame of five bytes in this order: PC[7:0], {000, PC[12:8]}, X, A, {111, CC[4:0]}.
- R8: `cmd_op`=0 saves a return address of two bytes in this order: PC[7:0], then {000, PC[12:8]}.
- R9: `cmd_op`=1 restores the PC from two reads (high byte first) and `cmd_op`=3 restores a frame from five reads (CC, A, X, PC high, PC low). Only bits 4:0 of the PC-high and CC bytes are kept. The restored values appear on the outputs in the cycle after `done`, and the outputs keep their values during save transfers.
- R10: A command accepted in an idle cycle starts its first access in the next cycle and makes exactly one access per cycle (never a write and a read together). `done` is high with the last access only, and `busy` is low in the cycle after it.
- R11: While `busy` is high, `cmd_valid`, `cmd_op` and the register inputs are ignored: the transfer in progress continues with the values captured when it was accepted.
- R12: While `busy` is high, `rsp_req` is ignored and the pointer keeps stepping.
- R13: If `rsp_req` and `cmd_valid` are both high in one idle cycle, the pointer is reset and the command is also accepted; its first access uses 0x007F (a save) or 0x0040 (a restore).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 save return address, 1 restore return address, 2 save frame, 3 restore frame |
| rsp_req | input | 1 | Reset the stack pointer to the page top |
| pc_in | input | 13 | Program counter to save |
| x_in | input | 8 | Index register to save |
| a_in | input | 8 | Accumulator to save |
| cc_in | input | 5 | Condition codes to save |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_re` |
| mem_addr | output | 13 | Stack access address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Last access of the transfer |
| sp_out | output | 13 | Current stack pointer |
| pc_out | output | 13 | Restored program counter |
| x_out | output | 8 | Restored index register |
| a_out | output | 8 | Restored accumulator |
| cc_out | output | 5 | Restored condition codes |

## Verification
Two functions can fall in the same cycle. A pointer reset and the acceptance of a command can arrive together in one idle cycle, and a pointer reset can also arrive while a transfer is stepping the pointer. The bench drives `rsp_req` together with `cmd_valid` at random and in directed cases. It also holds `rsp_req` and stray commands high through busy cycles. A reference pointer in the bench is reset only when the requirements say so, and each access address and the final `sp_out` are compared against it. A collision is correct when the first access lands on the page top (or, for a restore, on the page bottom) and a pointer reset during a transfer has no effect.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

  localparam int unsigned STEP_W = 3;

  // bit 1: full frame, bit 0: restore direction
  typedef enum logic [1:0] {
    OP_CALL = 2'd0,
    OP_RET  = 2'd1,
    OP_IRQ  = 2'd2,
    OP_RTI  = 2'd3
  } stk_op_e;

  typedef enum logic [2:0] {
    ROLE_PCL,
    ROLE_PCH,
    ROLE_X,
    ROLE_A,
    ROLE_CC
  } stk_role_e;

  function automatic logic op_is_pop(stk_op_e op);
    return (op == OP_RET) || (op == OP_RTI);
  endfunction

  function automatic logic [STEP_W-1:0] op_len(stk_op_e op);
    return ((op == OP_IRQ) || (op == OP_RTI)) ? STEP_W'(5) : STEP_W'(2);
  endfunction

  // slot order of a save; a restore walks the same slots backwards
  function automatic stk_role_e slot_role(logic [STEP_W-1:0] slot);
    case (slot)
      3'd0:    return ROLE_PCL;
      3'd1:    return ROLE_PCH;
      3'd2:    return ROLE_X;
      3'd3:    return ROLE_A;
      default: return ROLE_CC;
    endcase
  endfunction

  function automatic stk_role_e step_role(stk_op_e op, logic [STEP_W-1:0] step);
    logic [STEP_W-1:0] slot;
    slot = op_is_pop(op) ? (op_len(op) - STEP_W'(1) - step) : step;
    return slot_role(slot);
  endfunction

endpackage

// File: rtl/stkseq_ptr.sv
module stkseq_ptr #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_top,
  input  logic             step_dn,
  input  logic             step_up,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] TOP = '1;
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= TOP;
    else if (load_top) ptr <= TOP;
    else if (step_dn)  ptr <= ptr - ONE;
    else if (step_up)  ptr <= ptr + ONE;
  end

  p_top_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_top |=> ptr == TOP);

  // wraps modulo the page (R6)
  p_push_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |=> ptr == $past(ptr) - ONE);

  p_pop_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> ptr == $past(ptr) + ONE);

  p_rsp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_top |-> !(step_dn || step_up));

endmodule

// File: rtl/stkseq_ctl.sv
module stkseq_ctl
  import stkseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  stk_op_e           cmd_op,
  output logic              busy,
  output logic              accept,
  output logic              last,
  output logic              is_pop,
  output stk_op_e           op,
  output stk_role_e         role
);

  logic [STEP_W-1:0] step;

  assign accept = cmd_valid && !busy;
  assign last   = busy && (step == op_len(op) - STEP_W'(1));
  assign is_pop = op_is_pop(op);
  assign role   = step_role(op, step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      op   <= OP_CALL;
      step <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      op   <= cmd_op;
      step <= '0;
    end else if (busy) begin
      busy <= !last;
      step <= last ? '0 : step + STEP_W'(1);
    end
  end

  p_hold_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy && (op == $past(op)));

  p_step_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step < op_len(op));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);

endmodule

// File: rtl/stkseq_frame.sv
module stkseq_frame
  import stkseq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 13,
  parameter int CC_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] a_in,
  input  logic [CC_W-1:0]   cc_in,
  input  stk_role_e         role,
  input  logic              wr_strobe,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] wdata,
  output logic [PC_W-1:0]   pc_out,
  output logic [DATA_W-1:0] x_out,
  output logic [DATA_W-1:0] a_out,
  output logic [CC_W-1:0]   cc_out
);

  localparam int PCH_W    = PC_W - DATA_W;
  localparam int FILL_PCH = DATA_W - PCH_W;
  localparam int FILL_CC  = DATA_W - CC_W;

  logic [PC_W-1:0]   snap_pc;
  logic [DATA_W-1:0] snap_x, snap_a;
  logic [CC_W-1:0]   snap_cc;

  function automatic logic [DATA_W-1:0] pack_byte(stk_role_e r, logic [PC_W-1:0] pc,
      logic [DATA_W-1:0] xv, logic [DATA_W-1:0] av, logic [CC_W-1:0] ccv);
    case (r)
      ROLE_PCL: return pc[DATA_W-1:0];
      ROLE_PCH: return {{FILL_PCH{1'b0}}, pc[PC_W-1:DATA_W]};
      ROLE_X:   return xv;
      ROLE_A:   return av;
      default:  return {{FILL_CC{1'b1}}, ccv};
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_pc <= '0;
      snap_x  <= '0;
      snap_a  <= '0;
      snap_cc <= '0;
    end else if (capture) begin
      snap_pc <= pc_in;
      snap_x  <= x_in;
      snap_a  <= a_in;
      snap_cc <= cc_in;
    end
  end

  assign wdata = pack_byte(role, snap_pc, snap_x, snap_a, snap_cc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out <= '0;
      x_out  <= '0;
      a_out  <= '0;
      cc_out <= '0;
    end else if (rd_strobe) begin
      case (role)
        ROLE_PCL: pc_out[DATA_W-1:0]    <= rd_data;
        ROLE_PCH: pc_out[PC_W-1:DATA_W] <= rd_data[PCH_W-1:0];
        ROLE_X:   x_out                 <= rd_data;
        ROLE_A:   a_out                 <= rd_data;
        default:  cc_out                <= rd_data[CC_W-1:0];
      endcase
    end
  end

  p_pch_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && role == ROLE_PCH) |-> wdata[DATA_W-1:PCH_W] == '0);

  p_cc_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && role == ROLE_CC) |-> wdata[DATA_W-1:CC_W] == '1);

  p_restore_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(pc_out) && $stable(x_out) && $stable(a_out) && $stable(cc_out));

endmodule

// File: rtl/stkseq_top.sv
module stkseq_top
  import stkseq_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int PTR_W    = 6,
  parameter int DATA_W   = 8,
  parameter int PC_W     = 13,
  parameter int CC_W     = 5,
  parameter int PAGE_SEL = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              rsp_req,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] a_in,
  input  logic [CC_W-1:0]   cc_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sp_out,
  output logic [PC_W-1:0]   pc_out,
  output logic [DATA_W-1:0] x_out,
  output logic [DATA_W-1:0] a_out,
  output logic [CC_W-1:0]   cc_out
);

  localparam int               PREFIX_W = ADDR_W - PTR_W;
  localparam logic [PREFIX_W-1:0] PREFIX = PREFIX_W'(PAGE_SEL);
  localparam logic [PTR_W-1:0]    ONE    = PTR_W'(1);

  logic            accept, last, is_pop, load_top;
  stk_op_e         op;
  stk_role_e       role;
  logic [PTR_W-1:0] ptr, acc_ptr;

  assign load_top = rsp_req && !busy;
  assign mem_we   = busy && !is_pop;
  assign mem_re   = busy && is_pop;
  assign done     = last;
  assign acc_ptr  = is_pop ? ptr + ONE : ptr;
  assign mem_addr = {PREFIX, acc_ptr};
  assign sp_out   = {PREFIX, ptr};

  stkseq_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (stk_op_e'(cmd_op)),
    .busy     (busy),
    .accept   (accept),
    .last     (last),
    .is_pop   (is_pop),
    .op       (op),
    .role     (role)
  );

  stkseq_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_top(load_top),
    .step_dn (mem_we),
    .step_up (mem_re),
    .ptr     (ptr)
  );

  stkseq_frame #(.DATA_W(DATA_W), .PC_W(PC_W), .CC_W(CC_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept),
    .pc_in    (pc_in),
    .x_in     (x_in),
    .a_in     (a_in),
    .cc_in    (cc_in),
    .role     (role),
    .wr_strobe(mem_we),
    .rd_strobe(mem_re),
    .rd_data  (mem_rdata),
    .wdata    (mem_wdata),
    .pc_out   (pc_out),
    .x_out    (x_out),
    .a_out    (a_out),
    .cc_out   (cc_out)
  );

  p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_done_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_we || mem_re));

  p_start_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_pop_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp_out == $past(mem_addr));

  p_push_at_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == sp_out);

  p_collide_top_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rsp_req) |=> sp_out[PTR_W-1:0] == '1);

endmodule

// File: tb/tb_stkseq_top.sv
module tb_stkseq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, rsp_req;
  logic [1:0]  cmd_op;
  logic [12:0] pc_in;
  logic [7:0]  x_in, a_in;
  logic [4:0]  cc_in;
  logic [7:0]  mem_rdata;
  logic [12:0] mem_addr, sp_out, pc_out;
  logic [7:0]  mem_wdata, x_out, a_out;
  logic [4:0]  cc_out;
  logic        mem_we, mem_re, busy, done;

  always #10 clk = ~clk;

  stkseq_top dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .rsp_req(rsp_req),
    .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .busy(busy), .done(done), .sp_out(sp_out), .pc_out(pc_out), .x_out(x_out),
    .a_out(a_out), .cc_out(cc_out)
  );

  logic [7:0] bmem [0:63];   // memory seen by the design
  logic [7:0] emem [0:63];   // bench expectation of the page
  assign mem_rdata = bmem[mem_addr[5:0]];
  always @(posedge clk) if (mem_we) bmem[mem_addr[5:0]] <= mem_wdata;

  int checks = 0;
  int errors = 0;
  logic [5:0]  mptr;
  logic [12:0] epc;
  logic [7:0]  ex, ea;
  logic [4:0]  ecc;

  function automatic logic [12:0] page_addr(logic [5:0] p);
    return 13'h0040 | {7'd0, p};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(req, "busy idle", busy, 0);
    chk(req, "sp_out", sp_out, page_addr(mptr));
    chk("R3", "sp page", sp_out[12:6], 7'b0000001);
    chk("R9", "pc_out", pc_out, epc);
    chk("R9", "x_out", x_out, ex);
    chk("R9", "a_out", a_out, ea);
    chk("R9", "cc_out", cc_out, ecc);
  endtask

  task automatic do_rsp();
    @(negedge clk);
    rsp_req = 1'b1; cmd_valid = 1'b0;
    mptr = 6'h3F;
    @(negedge clk);
    rsp_req = 1'b0;
    check_idle("R2");
  endtask

  task automatic run(input logic [1:0] op, input logic [12:0] pc, input logic [7:0] xv,
                     input logic [7:0] av, input logic [4:0] ccv, input bit noise, input bit with_rsp,
                     input bit rsp_flood);
    int n;
    bit pop;
    logic [7:0] fr [5];
    n   = op[1] ? 5 : 2;
    pop = op[0];
    fr[0] = pc[7:0];
    fr[1] = {3'b000, pc[12:8]};
    fr[2] = xv;
    fr[3] = av;
    fr[4] = {3'b111, ccv};
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; rsp_req = with_rsp;
    pc_in = pc; x_in = xv; a_in = av; cc_in = ccv;
    if (with_rsp) mptr = 6'h3F;
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      int slot;
      @(negedge clk);
      cmd_valid = noise ? 1'($urandom) : 1'b0;
      cmd_op    = 2'($urandom);
      rsp_req   = rsp_flood ? 1'b1 : (noise ? ($urandom % 3 == 0) : 1'b0);
      pc_in = 13'($urandom); x_in = 8'($urandom); a_in = 8'($urandom); cc_in = 5'($urandom);
      chk("R10", "busy", busy, 1);
      chk("R10", "done", done, (i == n - 1));
      chk("R3", "addr page", mem_addr[12:6], 7'b0000001);
      if (!pop) begin
        chk("R4", "push addr", mem_addr, page_addr(mptr));
        chk("R10", "we/re", {mem_we, mem_re}, 2'b10);
        chk(op[1] ? "R7" : "R8", "push byte", mem_wdata, fr[i]);
        emem[mptr] = fr[i];
        mptr = mptr - 6'd1;
      end else begin
        mptr = mptr + 6'd1;
        chk("R5", "pop addr", mem_addr, page_addr(mptr));
        chk("R10", "we/re", {mem_we, mem_re}, 2'b01);
        b = emem[mptr];
        slot = n - 1 - i;
        case (slot)
          0: epc[7:0]  = b;
          1: epc[12:8] = b[4:0];
          2: ex        = b;
          3: ea        = b;
          default: ecc = b[4:0];
        endcase
      end
      @(posedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0; rsp_req = 1'b0;
    check_idle(rsp_flood ? "R12" : (noise ? "R11" : (with_rsp ? "R13" : "R9")));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 64; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      bmem[i] = v;
      emem[i] = v;
    end
    rst_n = 1'b0; cmd_valid = 1'b0; rsp_req = 1'b0; cmd_op = 2'd0;
    pc_in = '0; x_in = '0; a_in = '0; cc_in = '0;
    mptr = 6'h3F; epc = '0; ex = '0; ea = '0; ecc = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "sp reset", sp_out, 13'h007F);
    chk("R1", "busy reset", busy, 0);
    chk("R1", "done reset", done, 0);
    chk("R1", "strobes reset", {mem_we, mem_re}, 2'b00);
    chk("R1", "pc_out reset", pc_out, 0);
    chk("R1", "cc_out reset", {x_out, a_out, cc_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    // directed frames
    run(2'd2, 13'h1ABC, 8'h5A, 8'hC3, 5'h15, 0, 0, 0);   // R7
    run(2'd0, 13'h0F0E, 8'h00, 8'h00, 5'h00, 0, 0, 0);   // R8
    run(2'd1, 13'h0000, 8'h00, 8'h00, 5'h00, 0, 0, 0);   // R9 return
    run(2'd3, 13'h0000, 8'h00, 8'h00, 5'h00, 0, 0, 0);   // R9 frame
    do_rsp();                                              // R2
    // R6 wrap: 32 calls fill the page, the 33rd overwrites the top
    for (int k = 0; k < 33; k++) run(2'd0, 13'($urandom), 8'h0, 8'h0, 5'h0, 0, 0, 0);
    chk("R6", "wrapped sp", sp_out, 13'h007D);
    for (int k = 0; k < 34; k++) run(2'd1, 13'h0, 8'h0, 8'h0, 5'h0, 0, 0, 0);
    // R12 pointer reset held high through a transfer
    run(2'd2, 13'h1234, 8'h11, 8'h22, 5'h1F, 0, 0, 1);
    run(2'd3, 13'h0, 8'h0, 8'h0, 5'h0, 0, 0, 1);
    // R13 collision, save then restore
    run(2'd2, 13'h0777, 8'h99, 8'h88, 5'h0A, 0, 1, 0);
    run(2'd1, 13'h0, 8'h0, 8'h0, 5'h0, 0, 1, 0);
    // R11 stray commands during a transfer
    run(2'd2, 13'h1FFF, 8'hFF, 8'h01, 5'h1F, 1, 0, 0);

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      if ($urandom % 16 == 0) do_rsp();
      run(2'($urandom), 13'($urandom), 8'($urandom), 8'($urandom), 5'($urandom),
          1'($urandom), ($urandom % 8 == 0), ($urandom % 16 == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule